// File: doc/BRIEF.md
# Program Counter and Vector Unit

This block owns the 12-bit program counter of a small microcontroller with 4096 words of program memory. On ordinary instruction flow it presents the next sequential fetch address every cycle. It redirects execution on four kinds of control transfer: a full-width jump, a full-width call, a write to the counter's low byte, and an interrupt.

A low-byte write is the register write an instruction makes when it targets the counter's readable low-byte register at data address 06H. Decoding that address is left to the register file, which raises `low_wr`. The write replaces only bits 7..0, so the jump stays inside the current 256-word page. Interrupt requests arrive as levels with matching enables. A request is vectored only when its enable is set and the return stack reports that it is not full. Request bit i jumps to vector address 4*(i+1).

Every transfer is followed by one dummy cycle, flagged on `flush`, in which the fetched word is thrown away and the counter holds at its new target. Calls and interrupts also present the return address on `push_addr` with a `push_valid` strobe, for an external stack to store.

Top module: `pcv_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_addr` becomes 000H and `flush` and `push_valid` become 0.
- R2: In a cycle with no accepted request and `flush` low, `fetch_addr` advances by one at the next edge, wrapping from FFFH to 000H.
- R3: A `low_wr` with data D, taken when `fetch_addr` is P, loads `{P[11:8], D}`. The page is that of the current address, not of P+1.
- R4: A `xfer_valid` with `xfer_call` low loads `xfer_target` and raises no `push_valid`.
- R5: A `xfer_valid` with `xfer_call` high loads `xfer_target` and, in the same cycle, presents `push_valid`=1 with `push_addr` = P+1.
- R6: An accepted interrupt on request bit i loads vector 4*(i+1): bit0 004H, bit1 008H, bit2 00CH, bit3 010H, bit4 014H, bit5 018H, bit6 01CH.
- R7: A request is accepted only if its `irq_en` bit is 1 and `stack_full` is 0. Otherwise it has no effect, and the counter advances as in R2.
- R8: Priority runs accepted interrupt, then jump or call, then low-byte write. Among accepted interrupts the lowest bit index (lowest vector) wins.
- R9: Each transfer raises `flush` for exactly one cycle, starting the cycle after the request is accepted. During that cycle `fetch_addr` holds the target and every request input is ignored.
- R10: An accepted interrupt presents `push_valid`=1 with `push_addr` = P+1, where P is the address at which it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Full-width jump or call request |
| xfer_call | input | 1 | With xfer_valid: 1 = call (push return), 0 = jump |
| xfer_target | input | 12 | Jump or call target address |
| low_wr | input | 1 | Write to counter low byte (in-page jump) |
| low_wdata | input | 8 | Data written to the low byte |
| irq_req | input | 7 | Interrupt request levels, bit i to vector 4*(i+1) |
| irq_en | input | 7 | Per-request enables |
| stack_full | input | 1 | Return stack full; blocks interrupts |
| fetch_addr | output | 12 | Registered program counter / fetch address |
| flush | output | 1 | Dummy cycle: discard the fetched word |
| push_valid | output | 1 | Return address valid for the stack |
| push_addr | output | 12 | Return address (address of transfer + 1) |

## Verification
The hardest situation to reach is a request arriving inside the dummy cycle, together with the page boundary case for low-byte writes. Reaching the first means driving a request on exactly the cycle after a transfer. Reaching the second means parking the counter on a page's last word, where P and P+1 lie in different pages. The stimulus jumps to 5FFH, waits out the dummy cycle, and writes the low byte right away, so a design that took the page from P+1 would land in page 6. It also drives a low-byte write during a dummy cycle and checks that the counter still steps from the held target. Priority is exercised by driving several interrupts, and an interrupt together with a jump, in a single cycle.

// File: rtl/pcv_pkg.sv
package pcv_pkg;
  typedef enum logic [2:0] {
    SRC_SEQ,
    SRC_HOLD,
    SRC_PAGE,
    SRC_JUMP,
    SRC_CALL,
    SRC_VEC
  } pc_src_e;
endpackage

// File: rtl/pcv_irq_pick.sv
module pcv_irq_pick #(
  parameter int PC_W       = 12,
  parameter int N_IRQ      = 7,
  parameter int VEC_STRIDE = 4
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             stack_full,
  output logic             take,
  output logic [PC_W-1:0]  vec
);
  logic [N_IRQ-1:0] live;
  logic [PC_W-1:0]  vec_of [N_IRQ];

  assign live = irq_req & irq_en & {N_IRQ{~stack_full}};
  assign take = |live;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_vec
    assign vec_of[i] = PC_W'((i + 1) * VEC_STRIDE);
  end

  // lowest index wins: scan from the top down so the lowest overwrites
  always_comb begin
    vec = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (live[i]) vec = vec_of[i];
    end
  end
endmodule

// File: rtl/pcv_next.sv
module pcv_next
  import pcv_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int PAGE_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic              in_dummy,
  input  logic              irq_take,
  input  logic [PC_W-1:0]   irq_vec,
  input  logic              xfer_valid,
  input  logic              xfer_call,
  input  logic [PC_W-1:0]   xfer_target,
  input  logic              low_wr,
  input  logic [PAGE_W-1:0] low_wdata,
  output logic [PC_W-1:0]   nxt_pc,
  output pc_src_e           src
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  always_comb begin
    if (in_dummy) begin
      src    = SRC_HOLD;
      nxt_pc = pc;
    end else if (irq_take) begin
      src    = SRC_VEC;
      nxt_pc = irq_vec;
    end else if (xfer_valid) begin
      src    = xfer_call ? SRC_CALL : SRC_JUMP;
      nxt_pc = xfer_target;
    end else if (low_wr) begin
      src    = SRC_PAGE;
      nxt_pc = {pc[PC_W-1:PAGE_W], low_wdata};
    end else begin
      src    = SRC_SEQ;
      nxt_pc = pc + ONE;
    end
  end
endmodule

// File: rtl/pcv_unit.sv
module pcv_unit
  import pcv_pkg::*;
#(
  parameter int PC_W       = 12,
  parameter int PAGE_W     = 8,
  parameter int N_IRQ      = 7,
  parameter int VEC_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_valid,
  input  logic              xfer_call,
  input  logic [PC_W-1:0]   xfer_target,
  input  logic              low_wr,
  input  logic [PAGE_W-1:0] low_wdata,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic              stack_full,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              flush,
  output logic              push_valid,
  output logic [PC_W-1:0]   push_addr
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic            irq_take;
  logic [PC_W-1:0] irq_vec;
  logic [PC_W-1:0] nxt_pc;
  pc_src_e         src;
  logic            is_xfer;
  logic            is_push;

  pcv_irq_pick #(.PC_W(PC_W), .N_IRQ(N_IRQ), .VEC_STRIDE(VEC_STRIDE)) u_pick (
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .stack_full (stack_full),
    .take       (irq_take),
    .vec        (irq_vec)
  );

  pcv_next #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_next (
    .pc          (fetch_addr),
    .in_dummy    (flush),
    .irq_take    (irq_take),
    .irq_vec     (irq_vec),
    .xfer_valid  (xfer_valid),
    .xfer_call   (xfer_call),
    .xfer_target (xfer_target),
    .low_wr      (low_wr),
    .low_wdata   (low_wdata),
    .nxt_pc      (nxt_pc),
    .src         (src)
  );

  assign is_push = (src == SRC_CALL) || (src == SRC_VEC);
  assign is_xfer = is_push || (src == SRC_JUMP) || (src == SRC_PAGE);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr <= '0;
      flush      <= 1'b0;
      push_valid <= 1'b0;
      push_addr  <= '0;
    end else begin
      fetch_addr <= nxt_pc;
      flush      <= is_xfer;
      push_valid <= is_push;
      if (is_push) push_addr <= fetch_addr + ONE;
    end
  end
endmodule

// File: rtl/pcv_unit_chk.sv
module pcv_unit_chk #(
  parameter int PC_W   = 12,
  parameter int PAGE_W = 8,
  parameter int N_IRQ  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_valid,
  input logic              low_wr,
  input logic [N_IRQ-1:0]  irq_req,
  input logic [N_IRQ-1:0]  irq_en,
  input logic              stack_full,
  input logic [PC_W-1:0]   fetch_addr,
  input logic              flush,
  input logic              push_valid
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic irq_ok;
  logic any_req;
  assign irq_ok  = (|(irq_req & irq_en)) && !stack_full;
  assign any_req = irq_ok || xfer_valid || low_wr;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0) && !flush && !push_valid);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && !any_req) |=> (fetch_addr == $past(fetch_addr) + ONE) && !flush);

  // R3
  page_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && low_wr && !xfer_valid && !irq_ok)
      |=> flush && (fetch_addr[PC_W-1:PAGE_W] == $past(fetch_addr[PC_W-1:PAGE_W])));

  // R9
  dummy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> $stable(fetch_addr) && !flush);

  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && stack_full && !xfer_valid) |=> !push_valid);

  // R10
  push_in_dummy_chk: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> flush);
endmodule

bind pcv_unit pcv_unit_chk #(.PC_W(PC_W), .PAGE_W(PAGE_W), .N_IRQ(N_IRQ)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .xfer_valid (xfer_valid),
  .low_wr     (low_wr),
  .irq_req    (irq_req),
  .irq_en     (irq_en),
  .stack_full (stack_full),
  .fetch_addr (fetch_addr),
  .flush      (flush),
  .push_valid (push_valid)
);

// File: tb/pcv_unit_tb_top.sv
module pcv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        xfer_valid, xfer_call;
  logic [11:0] xfer_target;
  logic        low_wr;
  logic [7:0]  low_wdata;
  logic [6:0]  irq_req, irq_en;
  logic        stack_full;
  logic [11:0] fetch_addr, push_addr;
  logic        flush, push_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pcv_unit dut_i (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_call(xfer_call),
    .xfer_target(xfer_target), .low_wr(low_wr), .low_wdata(low_wdata),
    .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
    .fetch_addr(fetch_addr), .flush(flush), .push_valid(push_valid),
    .push_addr(push_addr)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle_in();
    xfer_valid = 0; xfer_call = 0; xfer_target = '0;
    low_wr = 0; low_wdata = '0; irq_req = '0; irq_en = '0; stack_full = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // jump and wait out the dummy cycle (fetch_addr = t, flush low)
  task automatic go_to(input logic [11:0] t);
    xfer_valid = 1; xfer_call = 0; xfer_target = t;
    tick();
    idle_in();
    tick();
  endtask

  task automatic t_reset();
    idle_in();
    rst = 1;
    tick(); tick();
    chk("R1 fetch_addr", fetch_addr, 0);
    chk("R1 flush", flush, 0);
    chk("R1 push_valid", push_valid, 0);
    rst = 0;
  endtask

  task automatic t_seq();
    tick(); chk("R2 step1", fetch_addr, 1);
    tick(); chk("R2 step2", fetch_addr, 2);
    chk("R2 no flush", flush, 0);
    go_to(12'hFFF);
    chk("R9 hold target", fetch_addr, 12'hFFF);
    tick(); chk("R2 wrap", fetch_addr, 0);
  endtask

  task automatic t_jump();
    xfer_valid = 1; xfer_target = 12'h3A0;
    tick();
    chk("R4 target", fetch_addr, 12'h3A0);
    chk("R9 flush up", flush, 1);
    chk("R4 no push", push_valid, 0);
    idle_in();
    low_wr = 1; low_wdata = 8'h55; irq_req = 7'h01; irq_en = 7'h01;
    xfer_valid = 1; xfer_target = 12'h777;
    tick();
    idle_in();
    chk("R9 dummy hold", fetch_addr, 12'h3A0);
    chk("R9 flush one cycle", flush, 0);
    tick();
    chk("R9 requests ignored", fetch_addr, 12'h3A1);
  endtask

  task automatic t_page();
    low_wr = 1; low_wdata = 8'h10;
    tick(); idle_in();
    chk("R3 in page", fetch_addr, 12'h310);
    chk("R3 flush", flush, 1);
    tick();
    go_to(12'h5FF);
    low_wr = 1; low_wdata = 8'h22;
    tick(); idle_in();
    chk("R3 page of P", fetch_addr, 12'h522);
    tick();
  endtask

  task automatic t_call();
    go_to(12'h120);
    xfer_valid = 1; xfer_call = 1; xfer_target = 12'h800;
    tick(); idle_in();
    chk("R5 target", fetch_addr, 12'h800);
    chk("R5 push_valid", push_valid, 1);
    chk("R5 push_addr", push_addr, 12'h121);
    tick();
    chk("R5 push drops", push_valid, 0);
  endtask

  task automatic t_vectors();
    for (int i = 0; i < 7; i++) begin
      go_to(12'h200 + 12'(i * 16));
      irq_req = 7'(1 << i); irq_en = 7'h7F;
      tick(); idle_in();
      chk($sformatf("R6 vector bit%0d", i), fetch_addr, (i + 1) * 4);
      chk("R10 push_valid", push_valid, 1);
      chk("R10 push_addr", push_addr, 12'h201 + i * 16);
      tick();
    end
  endtask

  task automatic t_gate();
    go_to(12'h400);
    irq_req = 7'h7F; irq_en = 7'h00;
    tick();
    chk("R7 disabled", fetch_addr, 12'h401);
    chk("R7 disabled no flush", flush, 0);
    irq_en = 7'h7F; stack_full = 1;
    tick();
    chk("R7 stack full", fetch_addr, 12'h402);
    chk("R7 stack full no push", push_valid, 0);
    irq_req = 7'h02; irq_en = 7'h01; stack_full = 0;
    tick(); idle_in();
    chk("R7 enable per bit", fetch_addr, 12'h403);
  endtask

  task automatic t_prio();
    irq_req = 7'h24; irq_en = 7'h7F;
    tick(); idle_in();
    chk("R8 lowest vector", fetch_addr, 12'h00C);
    tick();
    irq_req = 7'h40; irq_en = 7'h40; xfer_valid = 1; xfer_target = 12'h900;
    tick(); idle_in();
    chk("R8 irq over jump", fetch_addr, 12'h01C);
    tick();
    xfer_valid = 1; xfer_target = 12'hA50; low_wr = 1; low_wdata = 8'h03;
    tick(); idle_in();
    chk("R8 jump over low write", fetch_addr, 12'hA50);
    tick();
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1;
    idle_in();
    @(negedge clk);
    t_reset();
    t_seq();
    t_reset();
    t_jump();
    t_page();
    t_call();
    t_vectors();
    t_gate();
    t_prio();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule